// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from the main clock through two cascaded dividers. The first stage is a power-of-two prescaler. A 2-bit select picks a factor of 2, 4, 8 or 16, and the stage issues a single-cycle tick at that rate. The second stage counts those ticks. It toggles the serial clock once every (BRG+1) ticks, where BRG is a 6-bit select. One half period of the serial clock therefore lasts H = (BRG+1) * (2 << DIV) main-clock cycles, and a full period lasts 2H. A BRG value below 4 is treated as 4. The fastest serial rate is main/20 and the slowest is main/2048.

Besides the serial-clock level, the block gives a shift engine two single-cycle strobes. One marks each leading (rising) edge and the other marks each trailing (falling) edge. The serial clock idles low.

Control is a three-state machine:
- **IDLE**: the serial clock is low, the counters are held clear, and the selects are copied into working registers every cycle. Those registers reset to the minimum legal pair, BRG 4 and DIV 0.
- **RUN**: the counters advance.
- **DRAIN**: finishes a high phase after the enable has been dropped.

Transitions:
- IDLE→RUN when enable is high.
- RUN→IDLE when enable is low and the clock is low (or is falling on that edge).
- RUN→DRAIN when enable is low and the clock is high.
- DRAIN→IDLE on the closing trailing edge.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: After reset, and while disabled, `sclk` is 0 and neither `sclk_lead` nor `sclk_trail` is asserted.
- R2: The first leading strobe comes H clock edges after the edge that first samples `en` high, where H = (BRG+1) * (2 << DIV).
- R3: DIV values 0, 1, 2 and 3 scale the half period by 2, 4, 8 and 16 respectively.
- R4: While enabled, the clock has a 50% duty cycle: leading to trailing and trailing to leading are both H cycles.
- R5: A BRG value of 0 to 3 yields the same timing as BRG 4.
- R6: DIV 0 with BRG 4 gives a full period of 20 cycles, and DIV 3 with BRG 63 gives a full period of 2048 cycles.
- R7: Changing DIV or BRG while enabled does not alter the running period. The new values apply from the next enable.
- R8: Dropping `en` while `sclk` is high completes the high phase to its full length, with a trailing strobe, and then the block stays idle.
- R9: Dropping `en` while `sclk` is low stops the clock at once: no further strobes appear and `sclk` stays 0.
- R10: `sclk_lead` is a one-cycle strobe that coincides with `sclk` going high. `sclk_trail` is a one-cycle strobe that coincides with `sclk` going low. The two are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run request for the serial clock |
| div_sel | input | 2 | Power-of-two stage select (factor 2 << value) |
| brg_sel | input | 6 | Linear stage select (BRG+1 ticks per half period, minimum 4) |
| sclk | output | 1 | Serial clock level, idles low |
| sclk_lead | output | 1 | One-cycle strobe on each rising serial edge |
| sclk_trail | output | 1 | One-cycle strobe on each falling serial edge |

## Verification
The bench builds the block with its default parameters: a 2-bit power-of-two select, a 6-bit linear select and a floor of 4. With these it can reach both ends of the legal range, from a 10-cycle half period to a 1024-cycle one. The stimulus table covers every DIV value, clamped BRG values and both extremes. Directed runs cover mid-run select changes and disabling in each clock phase.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } presc_state_t;
endpackage

// File: rtl/presc_pow2_stage.sv
// Power-of-two prescaler: one tick every (2 << div) cycles while running.
module presc_pow2_stage #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PCNT_W = 1 << DIV_W;

    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] limit;

    always_comb begin
        limit = {PCNT_W{1'b1}} >> (PCNT_W - 1 - int'(div));
        tick  = !clr && (pcnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (clr)
            pcnt_q <= '0;
        else if (tick)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + 1'b1;
    end
endmodule

// File: rtl/presc_linear_stage.sv
// Linear stage: signals wrap after (brg+1) ticks.
module presc_linear_stage #(
    parameter int BRG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [BRG_W-1:0] brg,
    output logic             wrap
);
    logic [BRG_W-1:0] lcnt_q;

    assign wrap = tick && (lcnt_q == brg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lcnt_q <= '0;
        else if (clr)
            lcnt_q <= '0;
        else if (tick)
            lcnt_q <= wrap ? '0 : lcnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler #(
    parameter int DIV_W   = 2,
    parameter int BRG_W   = 6,
    parameter int BRG_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [BRG_W-1:0] brg_sel,
    output logic             sclk,
    output logic             sclk_lead,
    output logic             sclk_trail
);
    import spi_presc_pkg::*;

    localparam logic [BRG_W-1:0] BRG_FLOOR = BRG_W'(BRG_MIN);

    presc_state_t     state_q, state_d;
    logic [DIV_W-1:0] div_q;
    logic [BRG_W-1:0] brg_q, brg_eff;
    logic             sclk_q, lead_q, trail_q;
    logic             clr, tick, wrap, toggle;

    assign brg_eff = (brg_sel < BRG_FLOOR) ? BRG_FLOOR : brg_sel;
    assign clr     = (state_q == ST_IDLE);

    // Working selects follow the inputs only while idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            brg_q <= BRG_FLOOR;
        end else if (state_q == ST_IDLE) begin
            div_q <= div_sel;
            brg_q <= brg_eff;
        end
    end

    presc_pow2_stage #(.DIV_W(DIV_W)) pow2_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .div  (div_q),
        .tick (tick)
    );

    presc_linear_stage #(.BRG_W(BRG_W)) lin_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .tick (tick),
        .brg  (brg_q),
        .wrap (wrap)
    );

    // Next state and toggle decision.
    always_comb begin
        state_d = state_q;
        toggle  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en)
                    state_d = ST_RUN;
            end
            ST_RUN: begin
                toggle = wrap && (en || sclk_q);
                if (!en)
                    state_d = (sclk_q && !wrap) ? ST_DRAIN : ST_IDLE;
            end
            ST_DRAIN: begin
                toggle = wrap;
                if (wrap)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
        end else begin
            sclk_q  <= sclk_q ^ toggle;
            lead_q  <= toggle && !sclk_q;
            trail_q <= toggle && sclk_q;
        end
    end

    assign sclk       = sclk_q;
    assign sclk_lead  = lead_q;
    assign sclk_trail = trail_q;
endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic sclk,
    input logic lead,
    input logic trail
);
    assert_lead_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lead |-> (sclk && !$past(sclk)));

    assert_trail_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trail |-> (!sclk && $past(sclk)));

    assert_lead_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lead |=> !lead);

    assert_trail_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trail |=> !trail);

    assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead && trail));

    assert_rise_has_lead_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> lead);

    assert_low_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sclk) |=> (!sclk && !lead));

    assert_high_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && sclk) |=> (sclk || trail));
endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk chk_i (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .sclk (sclk),
    .lead (sclk_lead),
    .trail(sclk_trail)
);

// File: tb/spi_sclk_prescaler_tb_top.sv
`timescale 1ns/1ps
module spi_sclk_prescaler_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] div_sel = '0;
    logic [5:0] brg_sel = '0;
    logic       sclk, sclk_lead, sclk_trail;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    spi_sclk_prescaler dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .div_sel   (div_sel),
        .brg_sel   (brg_sel),
        .sclk      (sclk),
        .sclk_lead (sclk_lead),
        .sclk_trail(sclk_trail)
    );

    // {div, brg, expected half period}
    localparam int VEC [8][3] = '{
        '{0,  4,   10},
        '{0,  0,   10},
        '{1,  4,   20},
        '{1,  3,   20},
        '{2, 10,   88},
        '{0, 63,  128},
        '{3,  4,   80},
        '{3, 63, 1024}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts rising clock edges until the chosen strobe is seen.
    task automatic wait_strobe(input bit want_lead, input int limit, output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!(want_lead ? sclk_lead : sclk_trail) && n < limit);
    endtask

    task automatic quiet(input string req, input int cycles);
        int bad = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (sclk || sclk_lead || sclk_trail) bad++;
        end
        check(req, bad, 0);
    endtask

    initial begin
        int n;
        int h;
        string tag;
        repeat (3) @(negedge clk);
        check("R1 reset sclk", int'(sclk), 0);
        check("R1 reset strobes", int'(sclk_lead | sclk_trail), 0);
        rst_n = 1'b1;
        quiet("R1 disabled idle", 20);

        for (int i = 0; i < 8; i++) begin
            h = VEC[i][2];
            if (VEC[i][1] < 4) tag = "R5";
            else if (h == 10 || h == 1024) tag = "R6";
            else tag = "R3";
            @(negedge clk);
            div_sel = VEC[i][0][1:0];
            brg_sel = VEC[i][1][5:0];
            en = 1'b1;
            wait_strobe(1'b1, 3000, n);
            check({"R2 first lead ", tag}, n, h + 1);
            wait_strobe(1'b0, 3000, n);
            check({"R4 high phase ", tag}, n, h);
            wait_strobe(1'b1, 3000, n);
            check({"R4 low phase ", tag}, n, h);
            wait_strobe(1'b0, 3000, n);
            check({"R4 high phase 2 ", tag}, n, h);
            en = 1'b0;
            quiet("R9 stop while low", 2 * h);
        end

        // R7: mid-run select change is ignored; R8: disable while high
        @(negedge clk);
        div_sel = 2'd0;
        brg_sel = 6'd4;
        en = 1'b1;
        wait_strobe(1'b1, 3000, n);
        check("R2 first lead", n, 11);
        div_sel = 2'd3;
        brg_sel = 6'd63;
        wait_strobe(1'b0, 3000, n);
        check("R7 high phase unchanged", n, 10);
        wait_strobe(1'b1, 3000, n);
        check("R7 low phase unchanged", n, 10);
        en = 1'b0;
        check("R8 still high after disable", int'(sclk), 1);
        wait_strobe(1'b0, 3000, n);
        check("R8 full high phase", n, 10);
        quiet("R8 idle after drain", 40);

        // R7: new selects take effect at the next enable
        @(negedge clk);
        en = 1'b1;
        wait_strobe(1'b1, 3000, n);
        check("R7 new selects at enable", n, 1025);
        wait_strobe(1'b0, 3000, n);
        check("R6 slowest half period", n, 1024);
        en = 1'b0;
        quiet("R9 stop after trail", 100);

        // R9: disable in the middle of a low phase
        @(negedge clk);
        div_sel = 2'd1;
        brg_sel = 6'd5;
        en = 1'b1;
        wait_strobe(1'b1, 3000, n);
        check("R3 div1 brg5 first lead", n, 25);
        wait_strobe(1'b0, 3000, n);
        check("R4 div1 brg5 high", n, 24);
        repeat (7) @(negedge clk);
        en = 1'b0;
        quiet("R9 mid-low stop", 80);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule